// File: doc/BRIEF.md
# Host-to-Microcontroller Mailbox Register Bank

This block holds a bank of byte-wide mailbox registers that a host processor and an embedded microcontroller share. The host reaches the bank indirectly. It decodes two neighbouring I/O addresses from a programmable even base address. It writes a register number to the lower one (the index port) and then reads or writes the selected register through the upper one (the data port). The microcontroller has a direct port addressed by register number.

Registers 0 and 1 are command registers with asymmetric write rules. Register 0 carries commands from host to controller. A host write stores the byte and raises a controller interrupt request. A controller write discards its byte and zeroes the register, which tells the host that the command is done. Register 1 works the same way in the other direction and raises a host SMI-style request. Each request has its own enable and stays pending until the receiving side reads the command register or clears it through the interrupt control register. All other registers are plain storage. A small configuration write port sets the base address, the decoder enable and the interrupt controls.

Top module: `mbx_bank`

## Requirements
- R1: After reset every mailbox register, the index register, both read data outputs, both interrupt outputs, the base address, the enables and the decoder enable are all zero.
- R2: The index port is at base = {high[3:0], low[7:1], 0}, where config select 0 writes high and select 1 writes low (bit 0 of low is dropped). The data port is at base+1. When bit 0 written at config select 2 is clear, or when the address differs, the host access has no effect and a read returns 0x00.
- R3: A host write to the index port sets the 8-bit index. A host read of the index port returns it. A host read of either port presents its data on host_rdata at the clock edge that samples host_rd.
- R4: Registers 2 to 31 store a write from either side, can be read by either side and raise no interrupt.
- R5: A host write of register 0 stores the byte and sets the controller request.
- R6: A controller write of register 0 discards its data and forces the register to 0x00.
- R7: A controller write of register 1 stores the byte and sets the host SMI request.
- R8: A host write of register 1 discards its data and forces the register to 0x00.
- R9: Config select 3 bit 0 enables mc_irq and bit 1 enables host_smi. An output is high only when its request is pending and enabled. A request stays pending while it is disabled.
- R10: A controller read of register 0 clears the controller request. A host data-port read of register 1 clears the SMI request. Writing 1 to bit 2 or bit 3 at config select 3 clears the controller or the SMI request. A new request in the same cycle wins over a clear.
- R11: When both sides write the same command register in one cycle, only the host write takes effect.
- R12: With an index of 32 or more, a data-port read returns 0x00 and a data-port write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 base high, 1 base low, 2 enable, 3 interrupt control |
| cfg_wdata | input | 8 | Configuration write data |
| host_addr | input | 12 | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| mc_addr | input | 5 | Controller register number |
| mc_wr | input | 1 | Controller write strobe |
| mc_rd | input | 1 | Controller read strobe |
| mc_wdata | input | 8 | Controller write data |
| mc_rdata | output | 8 | Controller read data, registered |
| mc_irq | output | 1 | Interrupt request to the controller |
| host_smi | output | 1 | SMI-style request to the host |

## Verification
The hardest case to reach from the ports is a collision: both agents write the same command register in the same clock cycle. Through the host side this needs an earlier index write, and then the host data-port write and the controller write must be driven on the same falling edge. The bench does this for both command registers. It then reads each register back and checks the interrupt outputs, which shows that the controller's store and its request were both dropped. A second hard case is a request that stays pending while its enable is off. The bench reaches it by disabling the output, raising the request, and only then enabling the output again.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 12;
  localparam int NUM_REGS = 32;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int HI_BITS  = ADDR_W - DATA_W;

  typedef enum logic [1:0] {
    CFG_BASE_HI = 2'd0,
    CFG_BASE_LO = 2'd1,
    CFG_ENABLE  = 2'd2,
    CFG_IRQCTL  = 2'd3
  } cfg_sel_e;

  localparam int CMD_TO_MC   = 0;
  localparam int CMD_TO_HOST = 1;
endpackage

// File: rtl/mbx_cfg_decode.sv
module mbx_cfg_decode
  import mbx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [AW-1:0] host_addr,
  output logic          hit_index,
  output logic          hit_data,
  output logic          irqctl_we
);
  localparam int HB = AW - DW;

  logic [HB-1:0] base_hi_q;
  logic [DW-2:0] base_lo_q;
  logic          active_q;
  logic [AW-1:0] base;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi_q <= '0;
      base_lo_q <= '0;
      active_q  <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_BASE_HI: base_hi_q <= cfg_wdata[HB-1:0];
        CFG_BASE_LO: base_lo_q <= cfg_wdata[DW-1:1];
        CFG_ENABLE:  active_q  <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  assign base      = {base_hi_q, base_lo_q, 1'b0};
  assign hit_index = active_q && (host_addr == base);
  assign hit_data  = active_q && (host_addr == (base | {{(AW-1){1'b0}}, 1'b1}));
  assign irqctl_we = cfg_wr && (cfg_sel_e'(cfg_sel) == CFG_IRQCTL);

  assert_inactive_no_hit_R2: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !(hit_index || hit_data));
  assert_ports_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(hit_index && hit_data));
endmodule

// File: rtl/mbx_reg_bank.sv
module mbx_reg_bank
  import mbx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int N  = NUM_REGS,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_we,
  input  logic [AW-1:0] h_idx,
  input  logic [DW-1:0] h_wdata,
  input  logic          m_we,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] h_val,
  output logic [DW-1:0] m_val,
  output logic          ev_mc_req,
  output logic          ev_host_req
);
  logic [N-1:0][DW-1:0] regs;

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic          h_sel, m_sel;
    logic [DW-1:0] r_q;
    assign h_sel = h_we && (h_idx == AW'(i));
    assign m_sel = m_we && (m_addr == AW'(i));

    if (i == CMD_TO_MC) begin : g_cmd_to_mc
      always_ff @(posedge clk) begin
        if (rst)        r_q <= '0;
        else if (h_sel) r_q <= h_wdata;
        else if (m_sel) r_q <= '0;
      end
    end else if (i == CMD_TO_HOST) begin : g_cmd_to_host
      always_ff @(posedge clk) begin
        if (rst)        r_q <= '0;
        else if (h_sel) r_q <= '0;
        else if (m_sel) r_q <= m_wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)        r_q <= '0;
        else if (h_sel) r_q <= h_wdata;
        else if (m_sel) r_q <= m_wdata;
      end
    end
    assign regs[i] = r_q;
  end

  assign h_val = regs[h_idx];
  assign m_val = regs[m_addr];

  logic h_cmd0, h_cmd1, m_cmd0, m_cmd1;
  assign h_cmd0 = h_we && (h_idx == AW'(CMD_TO_MC));
  assign h_cmd1 = h_we && (h_idx == AW'(CMD_TO_HOST));
  assign m_cmd0 = m_we && (m_addr == AW'(CMD_TO_MC));
  assign m_cmd1 = m_we && (m_addr == AW'(CMD_TO_HOST));

  assign ev_mc_req   = h_cmd0;
  assign ev_host_req = m_cmd1 && !h_cmd1;

  assert_mc_write_zeroes_R6: assert property (@(posedge clk) disable iff (rst)
    (m_cmd0 && !h_cmd0) |=> (regs[CMD_TO_MC] == '0));
  assert_host_write_zeroes_R8: assert property (@(posedge clk) disable iff (rst)
    h_cmd1 |=> (regs[CMD_TO_HOST] == '0));
  assert_host_wins_cmd0_R11: assert property (@(posedge clk) disable iff (rst)
    (h_cmd0 && m_cmd0) |=> (regs[CMD_TO_MC] == $past(h_wdata)));
  assert_mc_store_cmd1_R7: assert property (@(posedge clk) disable iff (rst)
    (m_cmd1 && !h_cmd1) |=> (regs[CMD_TO_HOST] == $past(m_wdata)));
endmodule

// File: rtl/mbx_irq_ctl.sv
module mbx_irq_ctl
  import mbx_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_mc,
  input  logic          set_host,
  input  logic          rd_clr_mc,
  input  logic          rd_clr_host,
  input  logic          ctl_we,
  input  logic [DW-1:0] ctl_wdata,
  output logic          mc_irq,
  output logic          host_smi
);
  logic en_mc_q, en_host_q, pend_mc_q, pend_host_q;
  logic en_mc_d, en_host_d, pend_mc_d, pend_host_d;
  logic clr_mc, clr_host;

  always_comb begin
    en_mc_d     = ctl_we ? ctl_wdata[0] : en_mc_q;
    en_host_d   = ctl_we ? ctl_wdata[1] : en_host_q;
    clr_mc      = rd_clr_mc   || (ctl_we && ctl_wdata[2]);
    clr_host    = rd_clr_host || (ctl_we && ctl_wdata[3]);
    pend_mc_d   = set_mc   || (pend_mc_q   && !clr_mc);
    pend_host_d = set_host || (pend_host_q && !clr_host);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_mc_q     <= 1'b0;
      en_host_q   <= 1'b0;
      pend_mc_q   <= 1'b0;
      pend_host_q <= 1'b0;
      mc_irq      <= 1'b0;
      host_smi    <= 1'b0;
    end else begin
      en_mc_q     <= en_mc_d;
      en_host_q   <= en_host_d;
      pend_mc_q   <= pend_mc_d;
      pend_host_q <= pend_host_d;
      mc_irq      <= pend_mc_d && en_mc_d;
      host_smi    <= pend_host_d && en_host_d;
    end
  end

  assert_mc_req_sets_R5: assert property (@(posedge clk) disable iff (rst)
    set_mc |=> pend_mc_q);
  assert_host_req_sets_R7: assert property (@(posedge clk) disable iff (rst)
    set_host |=> pend_host_q);
  assert_pending_held_R9: assert property (@(posedge clk) disable iff (rst)
    (pend_mc_q && !rd_clr_mc && !ctl_we) |=> pend_mc_q);
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!en_mc_q && !ctl_we) |=> !mc_irq);
  assert_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_host && !set_host && !ctl_we) |=> !host_smi);
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int N  = NUM_REGS,
  localparam int RAW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic [AW-1:0]  host_addr,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic [RAW-1:0] mc_addr,
  input  logic           mc_wr,
  input  logic           mc_rd,
  input  logic [DW-1:0]  mc_wdata,
  output logic [DW-1:0]  mc_rdata,
  output logic           mc_irq,
  output logic           host_smi
);
  logic           hit_index, hit_data, irqctl_we;
  logic [DW-1:0]  index_q;
  logic           idx_ok;
  logic           bank_h_we;
  logic [DW-1:0]  h_val, m_val;
  logic           ev_mc_req, ev_host_req;
  logic           rd_clr_mc, rd_clr_host;

  mbx_cfg_decode #(.AW(AW), .DW(DW)) i_decode (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .host_addr (host_addr),
    .hit_index (hit_index),
    .hit_data  (hit_data),
    .irqctl_we (irqctl_we)
  );

  always_ff @(posedge clk) begin
    if (rst)                        index_q <= '0;
    else if (host_wr && hit_index)  index_q <= host_wdata;
  end

  assign idx_ok    = (index_q < DW'(N));
  assign bank_h_we = host_wr && hit_data && idx_ok;

  mbx_reg_bank #(.DW(DW), .N(N)) i_bank (
    .clk         (clk),
    .rst         (rst),
    .h_we        (bank_h_we),
    .h_idx       (index_q[RAW-1:0]),
    .h_wdata     (host_wdata),
    .m_we        (mc_wr),
    .m_addr      (mc_addr),
    .m_wdata     (mc_wdata),
    .h_val       (h_val),
    .m_val       (m_val),
    .ev_mc_req   (ev_mc_req),
    .ev_host_req (ev_host_req)
  );

  assign rd_clr_mc   = mc_rd && (mc_addr == RAW'(CMD_TO_MC));
  assign rd_clr_host = host_rd && hit_data && (index_q == DW'(CMD_TO_HOST));

  mbx_irq_ctl #(.DW(DW)) i_irq (
    .clk         (clk),
    .rst         (rst),
    .set_mc      (ev_mc_req),
    .set_host    (ev_host_req),
    .rd_clr_mc   (rd_clr_mc),
    .rd_clr_host (rd_clr_host),
    .ctl_we      (irqctl_we),
    .ctl_wdata   (cfg_wdata),
    .mc_irq      (mc_irq),
    .host_smi    (host_smi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      mc_rdata   <= '0;
    end else begin
      if (host_rd) begin
        if (hit_index)              host_rdata <= index_q;
        else if (hit_data && idx_ok) host_rdata <= h_val;
        else                        host_rdata <= '0;
      end
      if (mc_rd) mc_rdata <= m_val;
    end
  end

  assert_oob_reads_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (host_rd && hit_data && !idx_ok) |=> (host_rdata == '0));
  assert_miss_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !hit_index && !hit_data) |=> (host_rdata == '0));
  assert_index_readback_R3: assert property (@(posedge clk) disable iff (rst)
    (host_rd && hit_index) |=> (host_rdata == $past(index_q)));
endmodule

// File: tb/test_mbx_bank.sv
module test_mbx_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 37;

  // op: 0 cfg write, 1 host write, 2 host read, 3 mc write, 4 mc read, 5 irq outputs
  // fields: op[34:32] addr[31:20] data[19:12] expect[11:4] req[3:0]
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 12'h000, 8'h03, 8'h00, 4'd2},   // base high   (R2)
    {3'd0, 12'h001, 8'h62, 8'h00, 4'd2},   // base low -> base 0x362 (R2)
    {3'd0, 12'h002, 8'h01, 8'h00, 4'd2},   // decoder on (R2)
    {3'd0, 12'h003, 8'h03, 8'h00, 4'd9},   // both outputs enabled (R9)
    {3'd1, 12'h362, 8'h05, 8'h00, 4'd3},   // index 5 (R3)
    {3'd2, 12'h362, 8'h00, 8'h05, 4'd3},   // index readback (R3)
    {3'd1, 12'h363, 8'hA5, 8'h00, 4'd4},
    {3'd2, 12'h363, 8'h00, 8'hA5, 4'd4},   // host store/read (R4)
    {3'd4, 12'h005, 8'h00, 8'hA5, 4'd4},   // seen by controller (R4)
    {3'd3, 12'h005, 8'h3C, 8'h00, 4'd4},
    {3'd2, 12'h363, 8'h00, 8'h3C, 4'd4},   // controller store seen by host (R4)
    {3'd5, 12'h000, 8'h00, 8'h00, 4'd4},   // no interrupts from plain regs (R4)
    {3'd1, 12'h362, 8'h00, 8'h00, 4'd5},
    {3'd1, 12'h363, 8'h77, 8'h00, 4'd5},   // host command (R5)
    {3'd5, 12'h000, 8'h00, 8'h01, 4'd5},   // mc_irq up (R5)
    {3'd4, 12'h000, 8'h00, 8'h77, 4'd5},   // controller reads command (R5)
    {3'd5, 12'h000, 8'h00, 8'h00, 4'd10},  // read cleared request (R10)
    {3'd3, 12'h000, 8'hFF, 8'h00, 4'd6},   // controller completes (R6)
    {3'd2, 12'h363, 8'h00, 8'h00, 4'd6},   // zeroed (R6)
    {3'd5, 12'h000, 8'h00, 8'h00, 4'd6},
    {3'd3, 12'h001, 8'h42, 8'h00, 4'd7},   // controller command (R7)
    {3'd5, 12'h000, 8'h00, 8'h02, 4'd7},   // host_smi up (R7)
    {3'd1, 12'h362, 8'h01, 8'h00, 4'd7},
    {3'd2, 12'h363, 8'h00, 8'h42, 4'd7},   // host reads it (R7)
    {3'd5, 12'h000, 8'h00, 8'h00, 4'd10},  // read cleared SMI (R10)
    {3'd1, 12'h363, 8'h99, 8'h00, 4'd8},   // host completes (R8)
    {3'd4, 12'h001, 8'h00, 8'h00, 4'd8},   // zeroed (R8)
    {3'd5, 12'h000, 8'h00, 8'h00, 4'd8},
    {3'd1, 12'h362, 8'h25, 8'h00, 4'd12},  // index 37 (R12)
    {3'd1, 12'h363, 8'h11, 8'h00, 4'd12},  // ignored write (R12)
    {3'd2, 12'h363, 8'h00, 8'h00, 4'd12},  // reads zero (R12)
    {3'd4, 12'h005, 8'h00, 8'h3C, 4'd12},  // reg 5 untouched (R12)
    {3'd2, 12'h362, 8'h00, 8'h25, 4'd3},   // 8-bit index kept (R3)
    {3'd1, 12'h364, 8'h02, 8'h00, 4'd2},   // off-base write (R2)
    {3'd2, 12'h362, 8'h00, 8'h25, 4'd2},   // index unchanged (R2)
    {3'd2, 12'h360, 8'h00, 8'h00, 4'd2},   // miss reads zero (R2)
    {3'd2, 12'h361, 8'h00, 8'h00, 4'd2}    // odd below base misses (R2)
  };

  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_wr = 0;
  logic [1:0]  cfg_sel = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [11:0] host_addr = 0;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_wdata = 0;
  logic [7:0]  host_rdata;
  logic [4:0]  mc_addr = 0;
  logic        mc_wr = 0, mc_rd = 0;
  logic [7:0]  mc_wdata = 0;
  logic [7:0]  mc_rdata;
  logic        mc_irq, host_smi;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_bank i_mbx_bank (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mc_addr(mc_addr), .mc_wr(mc_wr), .mc_rd(mc_rd),
    .mc_wdata(mc_wdata), .mc_rdata(mc_rdata),
    .mc_irq(mc_irq), .host_smi(host_smi)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic hwr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic hrd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1; host_addr = a;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  task automatic mwr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); mc_wr = 1; mc_addr = a; mc_wdata = d;
    @(negedge clk); mc_wr = 0;
  endtask

  task automatic mrd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); mc_rd = 1; mc_addr = a;
    @(negedge clk); mc_rd = 0; d = mc_rdata;
  endtask

  task automatic both_wr(input logic [4:0] r, input logic [7:0] hd, input logic [7:0] md);
    @(negedge clk);
    host_wr = 1; host_addr = 12'h363; host_wdata = hd;
    mc_wr = 1; mc_addr = r; mc_wdata = md;
    @(negedge clk); host_wr = 0; mc_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", host_rdata, 8'h00);
    chk("R1", mc_rdata, 8'h00);
    chk("R1", {6'b0, host_smi, mc_irq}, 8'h00);
    hrd(12'h000, rv); chk("R1", rv, 8'h00);   // decoder off, base 0
    mrd(5'd0, rv);    chk("R1", rv, 8'h00);
    mrd(5'd31, rv);   chk("R1", rv, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [11:0] a;
      logic [7:0]  d, e;
      string tag;
      op = VEC[i][34:32]; a = VEC[i][31:20]; d = VEC[i][19:12]; e = VEC[i][11:4];
      tag = $sformatf("R%0d", VEC[i][3:0]);
      case (op)
        3'd0: cfg(a[1:0], d);
        3'd1: hwr(a, d);
        3'd2: begin hrd(a, rv); chk(tag, rv, e); end
        3'd3: mwr(a[4:0], d);
        3'd4: begin mrd(a[4:0], rv); chk(tag, rv, e); end
        default: begin @(negedge clk); chk(tag, {6'b0, host_smi, mc_irq}, e); end
      endcase
    end

    // R9: request held while disabled, shown once enabled
    cfg(2'd3, 8'h00);
    hwr(12'h362, 8'h00);
    hwr(12'h363, 8'h5A);
    @(negedge clk); chk("R9", {7'b0, mc_irq}, 8'h00);
    cfg(2'd3, 8'h01);
    @(negedge clk); chk("R9", {7'b0, mc_irq}, 8'h01);
    // R10: software clear
    cfg(2'd3, 8'h07);
    @(negedge clk); chk("R10", {6'b0, host_smi, mc_irq}, 8'h00);

    // R11: simultaneous writes, host wins
    cfg(2'd3, 8'h03);
    both_wr(5'd0, 8'hAA, 8'h55);
    mrd(5'd0, rv); chk("R11", rv, 8'hAA);
    hwr(12'h362, 8'h01);
    mwr(5'd1, 8'h66);           // host_smi now pending
    cfg(2'd3, 8'h0B);           // clear SMI, keep enables
    both_wr(5'd1, 8'h12, 8'h34);
    @(negedge clk); chk("R11", {7'b0, host_smi}, 8'h00);
    mrd(5'd1, rv); chk("R11", rv, 8'h00);

    // R2: decoder disabled ignores host
    cfg(2'd2, 8'h00);
    hwr(12'h362, 8'h07);
    hrd(12'h362, rv); chk("R2", rv, 8'h00);
    cfg(2'd2, 8'h01);
    hrd(12'h362, rv); chk("R2", rv, 8'h01);
    // R2: base bits outside A11..A8 and bit 0 ignored
    cfg(2'd0, 8'hF8);           // high -> 0x8
    cfg(2'd1, 8'h11);           // low  -> 0x10
    hrd(12'h810, rv); chk("R2", rv, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule